// File: doc/BRIEF.md
# Per-Processor Software Interrupt Register

This block is the interrupt register that sits beside one processor. It keeps a 32-bit pending word. The lower half holds level bits that the system interrupt controller raises and drops through a dedicated hardware port. The upper half holds software interrupt bits, which a processor sets and clears through a small word-addressed register channel.

The block merges two sources into the processor's 16 interrupt level lines. The first is the level vector that the system controller routes to this processor. The second is the software half of the pending word, shifted down by sixteen places, so that pending bit 16+n drives level n. System-level masking and the choice of target processor are handled upstream and are not part of this block.

Register traffic uses a valid/ready request channel and a valid/ready read-response channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Only reads return a response. `req_ready` is low while a read response is waiting and `rsp_ready` is low, so a stalled response holds back every later request until it is taken. A held response keeps its data unchanged.

Top module: `icpu_softint`

## Requirements
- R1: While `rst_n` is low, every pending bit is cleared and `rsp_valid` is low. Right after reset, `lvl_out` equals `routed_lvl`.
- R2: A read of word 0 returns the whole 32-bit pending word. A read of any other word returns zero.
- R3: A write to word 2 ORs `req_wdata & 0xFFFE0000` into the pending word.
- R4: A write to word 1 clears the pending bits selected by `req_wdata & 0xFFFE0000`. If data bit 14 is set, bit 31 is cleared as well.
- R5: Writes to words other than 1 and 2 change nothing. Data bits 16 down to 0 of a set or clear write change nothing. In particular, pending bit 16 always stays zero.
- R6: When `hw_valid` is high, pending bit `hw_level` (0..15) takes the value of `hw_set` at the clock edge: 1 sets the bit and 0 clears it.
- R7: A hardware update and a software write in the same cycle both take effect. Hardware only touches bits 15..0 and software only touches bits 31..17, so the two never collide.
- R8: `lvl_out[n]` is `routed_lvl[n] | pending[16+n]`, with no register on the way. Because pending bit 16 stays zero, level 0 follows `routed_lvl[0]` alone.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. A read response appears one cycle after acceptance and carries the pending value from before that edge's updates. It stays valid and stable until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_rdata | output | 32 | Read response data |
| hw_valid | input | 1 | Hardware level update strobe |
| hw_set | input | 1 | 1 = set the level bit, 0 = clear it |
| hw_level | input | 4 | Level bit index to update |
| routed_lvl | input | 16 | Level vector routed from the system controller |
| lvl_out | output | 16 | Interrupt level lines to the processor |

## Verification
The bench builds the block with its defaults: 16 levels and a 4-bit word address. This lets random addresses land on the three mapped words and also on unmapped ones. Every one of the 16 hardware level positions can be hit, including level 14. Level 14 is the bit whose software-clear alias reaches bit 31, so the bench can check that a clear with data bit 14 set removes bit 31 without touching hardware bit 14. The 32-bit data width puts the fixed soft-bit mask, and the permanently-zero bit 16 behind level 0, under random write data.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  localparam int unsigned WORD_PEND = 0;
  localparam int unsigned WORD_CLR  = 1;
  localparam int unsigned WORD_SET  = 2;

  typedef struct packed {
    logic do_set;
    logic do_clr;
  } sw_op_t;
endpackage

// File: rtl/icpu_req_if.sv
module icpu_req_if
  import icpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] pend,
  output sw_op_t            sw_op,
  output logic [DATA_W-1:0] sw_data
);
  logic take;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    sw_op.do_set = take && req_write && (req_addr == ADDR_W'(WORD_SET));
    sw_op.do_clr = take && req_write && (req_addr == ADDR_W'(WORD_CLR));
  end
  assign sw_data = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= (req_addr == ADDR_W'(WORD_PEND)) ? pend : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/icpu_pend_reg.sv
module icpu_pend_reg
  import icpu_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 16,
  parameter int unsigned DATA_W     = 2 * NUM_LEVELS,
  parameter int unsigned LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sw_op_t            sw_op,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              hw_valid,
  input  logic              hw_set,
  input  logic [LVL_W-1:0]  hw_level,
  output logic [DATA_W-1:0] pend_q
);
  // soft bits: everything above the lowest soft-half bit
  localparam logic [DATA_W-1:0] SOFT_MASK  = {DATA_W{1'b1}} << (NUM_LEVELS + 1);
  localparam int unsigned       ALIAS_SRC  = NUM_LEVELS - 2;
  localparam logic [DATA_W-1:0] ALIAS_DST  = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] pend_d;

  always_comb begin
    clr_vec = (sw_data | (sw_data[ALIAS_SRC] ? ALIAS_DST : '0)) & SOFT_MASK;
    set_vec = sw_data & SOFT_MASK;
    pend_d  = pend_q;
    if (sw_op.do_clr) pend_d = pend_d & ~clr_vec;
    if (sw_op.do_set) pend_d = pend_d | set_vec;
    if (hw_valid)     pend_d[hw_level] = hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/icpu_lvl_merge.sv
module icpu_lvl_merge #(
  parameter int unsigned NUM_LEVELS = 16,
  parameter int unsigned DATA_W     = 2 * NUM_LEVELS
) (
  input  logic [NUM_LEVELS-1:0] routed_lvl,
  input  logic [DATA_W-1:0]     pend,
  output logic [NUM_LEVELS-1:0] lvl_out
);
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    assign lvl_out[g] = routed_lvl[g] | pend[NUM_LEVELS + g];
  end
endmodule

// File: rtl/icpu_softint.sv
module icpu_softint
  import icpu_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 16,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 2 * NUM_LEVELS,
  parameter int unsigned LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_rdata,
  input  logic                  hw_valid,
  input  logic                  hw_set,
  input  logic [LVL_W-1:0]      hw_level,
  input  logic [NUM_LEVELS-1:0] routed_lvl,
  output logic [NUM_LEVELS-1:0] lvl_out
);
  sw_op_t            sw_op;
  logic [DATA_W-1:0] sw_data;
  logic [DATA_W-1:0] pend_q;

  icpu_req_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pend(pend_q), .sw_op(sw_op), .sw_data(sw_data)
  );

  icpu_pend_reg #(.NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .sw_op(sw_op), .sw_data(sw_data),
    .hw_valid(hw_valid), .hw_set(hw_set), .hw_level(hw_level), .pend_q(pend_q)
  );

  icpu_lvl_merge #(.NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W)) u_merge (
    .routed_lvl(routed_lvl), .pend(pend_q), .lvl_out(lvl_out)
  );
endmodule

// File: rtl/icpu_softint_chk.sv
module icpu_softint_chk #(
  parameter int unsigned NUM_LEVELS = 16,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 2 * NUM_LEVELS,
  parameter int unsigned LVL_W      = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_write,
  input logic [ADDR_W-1:0]     req_addr,
  input logic [DATA_W-1:0]     req_wdata,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [DATA_W-1:0]     rsp_rdata,
  input logic                  hw_valid,
  input logic                  hw_set,
  input logic [LVL_W-1:0]      hw_level,
  input logic [NUM_LEVELS-1:0] routed_lvl,
  input logic [NUM_LEVELS-1:0] lvl_out,
  input logic [DATA_W-1:0]     pend
);
  localparam logic [DATA_W-1:0] SMASK = {DATA_W{1'b1}} << (NUM_LEVELS + 1);

  logic wr_take;
  assign wr_take = req_valid && req_ready && req_write;

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> (pend == '0 && !rsp_valid));

  p_soft_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && req_addr == ADDR_W'(2)) |=>
      ((pend & $past(req_wdata) & SMASK) == ($past(req_wdata) & SMASK)));

  p_soft_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && req_addr == ADDR_W'(1)) |=> ((pend & $past(req_wdata) & SMASK) == '0));

  p_bit16_zero_r5: assert property (@(posedge clk) disable iff (!rst_n) !pend[NUM_LEVELS]);

  p_hw_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_valid |=> (pend[$past(hw_level)] == $past(hw_set)));

  p_lvl_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_out == (routed_lvl | pend[DATA_W-1:NUM_LEVELS]));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind icpu_softint icpu_softint_chk #(
  .NUM_LEVELS(NUM_LEVELS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .hw_valid(hw_valid), .hw_set(hw_set), .hw_level(hw_level),
  .routed_lvl(routed_lvl), .lvl_out(lvl_out), .pend(pend_q)
);

// File: tb/icpu_softint_bench.sv
`timescale 1ns/1ps
module icpu_softint_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_rdata;
  logic        hw_valid, hw_set;
  logic [3:0]  hw_level;
  logic [15:0] routed_lvl, lvl_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] m_pend;

  always #5 clk = ~clk;

  icpu_softint u_icpu_softint (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .hw_valid(hw_valid), .hw_set(hw_set), .hw_level(hw_level),
    .routed_lvl(routed_lvl), .lvl_out(lvl_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] f_set(logic [31:0] m, logic [31:0] d);
    return m | (d & 32'hFFFE0000);
  endfunction

  function automatic logic [31:0] f_clr(logic [31:0] m, logic [31:0] d);
    logic [31:0] c;
    c = d;
    if (d[14]) c[31] = 1'b1;
    return m & ~(c & 32'hFFFE0000);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check level lines, step, check response
  task automatic step(input bit v, input bit w, input logic [3:0] a, input logic [31:0] d,
                      input bit hv, input bit hs, input logic [3:0] hl,
                      input logic [15:0] rt, input string req);
    bit acc;
    logic [31:0] exp_rd;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    hw_valid = hv; hw_set = hs; hw_level = hl; routed_lvl = rt;
    #1;
    chk(lvl_out == (rt | m_pend[31:16]), "R8", {16'h0, lvl_out}, {16'h0, rt | m_pend[31:16]});
    acc = v && req_ready;
    exp_rd = (a == 4'd0) ? m_pend : 32'h0;
    @(posedge clk);
    if (acc && w) begin
      if (a == 4'd1) m_pend = f_clr(m_pend, d);
      if (a == 4'd2) m_pend = f_set(m_pend, d);
    end
    if (hv) m_pend[hl] = hs;
    @(negedge clk);
    req_valid = 1'b0; hw_valid = 1'b0;
    if (acc && !w) begin
      chk(rsp_valid === 1'b1, {req, "/R9 valid"}, {31'h0, rsp_valid}, 32'h1);
      chk(rsp_rdata === exp_rd, req, rsp_rdata, exp_rd);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    rsp_ready = 1; hw_valid = 0; hw_set = 0; hw_level = 0; routed_lvl = 16'h5A3C;
    m_pend = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(lvl_out == 16'h5A3C, "R1 lvl", {16'h0, lvl_out}, 32'h5A3C);
    chk(rsp_valid == 1'b0, "R1 rsp", {31'h0, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0, 0, 16'h0, "R1 read");
    // soft set: low bits and bit 16 ignored
    step(1, 1, 2, 32'hFFFFFFFF, 0, 0, 0, 16'h0, "R3");
    step(1, 0, 0, 0, 0, 0, 0, 16'h0, "R3 read");
    chk(m_pend == 32'hFFFE0000, "R5 mask", m_pend, 32'hFFFE0000);
    chk(lvl_out == 16'hFFFE, "R8 level0", {16'h0, lvl_out}, 32'hFFFE);
    // clear with only data bit 14: bit 31 goes
    step(1, 1, 1, 32'h00004000, 0, 0, 0, 16'h0, "R4");
    step(1, 0, 0, 0, 0, 0, 0, 16'h0, "R4 read");
    // unmapped writes and reads
    step(1, 1, 3, 32'hFFFFFFFF, 0, 0, 0, 16'h0, "R5");
    step(1, 1, 0, 32'h00000000, 0, 0, 0, 16'h0, "R5");
    step(1, 0, 1, 0, 0, 0, 0, 16'h0, "R2 word1");
    step(1, 0, 3, 0, 0, 0, 0, 16'h0, "R2 word3");
    step(1, 0, 0, 0, 0, 0, 0, 16'h0, "R5 read");
    // hardware set level 14, then a soft clear of data bit 14 keeps it
    step(0, 0, 0, 0, 1, 1, 14, 16'h0, "R6");
    step(1, 1, 1, 32'h00004000, 1, 1, 3, 16'h0, "R7");
    step(1, 0, 0, 0, 0, 0, 0, 16'h0, "R7 read");
    step(0, 0, 0, 0, 1, 0, 14, 16'h0, "R6 clr");
    step(1, 0, 0, 0, 1, 1, 0, 16'h0, "R9 pre-update read");
    step(1, 0, 0, 0, 0, 0, 0, 16'h0, "R6 read");
    // back-pressure
    rsp_ready = 0;
    step(1, 0, 0, 0, 0, 0, 0, 16'h0, "R9 stall read");
    begin
      logic [31:0] held;
      held = rsp_rdata;
      chk(req_ready == 1'b0, "R9 ready", {31'h0, req_ready}, 0);
      step(1, 1, 2, 32'h00020000, 0, 0, 0, 16'h0, "R9");
      chk(rsp_valid && rsp_rdata == held, "R9 hold", rsp_rdata, held);
      rsp_ready = 1;
      #1;
      chk(req_ready == 1'b1, "R9 release", {31'h0, req_ready}, 1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9 drop", {31'h0, rsp_valid}, 0);
    end
    step(1, 0, 0, 0, 0, 0, 0, 16'h0, "R9 write dropped");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1] | r[2], 4'($urandom % 6), $urandom, r[3], r[4], r[8:5],
           16'($urandom), r[1] | r[2] ? "R3/R4 rand" : "R2 rand");
    end
    step(1, 0, 0, 0, 0, 0, 0, 16'h0, "R2 final");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule